// File: doc/BRIEF.md
# Four-phase request/acknowledge word link between two clock domains

This block carries data words from a sending unit to a receiving unit whose clocks are unrelated. The two units share no clock. They are joined by a data bus, a request line and an acknowledge line. The sender drives the request line and the receiver drives the acknowledge line, so each line has exactly one driver. A high request means "data valid" and a high acknowledge means "data accepted". Every word uses the full return-to-zero cycle: request rises, acknowledge rises, request falls, acknowledge falls. Only after that can the next word begin.

On the sending side, a local unit offers a word through a valid/ready/data push port in the sender's clock. On the receiving side, each delivered word appears on a data port together with a one-cycle valid pulse in the receiver's clock. Each control line crosses into the opposite domain through a chain of synchronizer flops. The data bus is not synchronized. It is held steady for as long as request is high, so the receiver can capture it directly.

Top module: `hs4_link`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, and both the request and acknowledge lines are low.
- R2: When `tx_valid` and `tx_ready` are both 1 at a rising `tx_clk` edge, the word is taken and `tx_ready` is 0 from that edge on.
- R3: The data bus is loaded one sender cycle before request rises. It keeps the same value on every cycle in which request stays high.
- R4: Request rises only while the sender sees acknowledge low. It falls only after the sender has seen acknowledge high.
- R5: Acknowledge rises only after the receiver has seen request high and captured the bus. It falls only after the receiver has seen request low.
- R6: `rx_valid` is a single-cycle pulse. It is issued on the same `rx_clk` edge on which acknowledge rises, and `rx_data` then holds the captured word.
- R7: Every accepted word arrives on `rx_data` exactly once and in the order it was pushed, with no loss and no duplicate.
- R8: `tx_ready` stays 0 from acceptance until the sender has seen acknowledge low again. While `tx_ready` is 0, `tx_valid` and `tx_data` are ignored, and no extra word reaches `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sender clock |
| tx_rst_n | input | 1 | Sender reset, asynchronous, active low |
| tx_valid | input | 1 | Sender offers a word |
| tx_ready | output | 1 | Sender can take a word this cycle |
| tx_data | input | WIDTH | Word offered by the sender |
| rx_clk | input | 1 | Receiver clock |
| rx_rst_n | input | 1 | Receiver reset, asynchronous, active low |
| rx_valid | output | 1 | One-cycle pulse: a word has been delivered |
| rx_data | output | WIDTH | Last delivered word |

## Verification
The bench builds the link with `WIDTH` = 12 and `SYNC_STAGES` = 2. The sender runs at 8 ns and the receiver at 13 ns, so the phase between the two domains keeps drifting from word to word. The 12-bit width makes room for all-zero, all-one and alternating bit patterns, plus an incrementing run. The two-stage chains keep each round trip short, so many words fit in one run. The junk data driven while `tx_ready` is low falls inside the whole round trip, which lets a leaked or duplicated word show up in the ordered comparison.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

  typedef enum logic [1:0] {
    SND_IDLE    = 2'd0,
    SND_LOAD    = 2'd1,
    SND_ASSERT  = 2'd2,
    SND_RELEASE = 2'd3
  } snd_state_t;

  typedef enum logic {
    RCV_WAIT = 1'b0,
    RCV_HOLD = 1'b1
  } rcv_state_t;

  // Sender step: a word is taken in IDLE, the bus settles in LOAD, request
  // is held in ASSERT until acknowledge is seen, and RELEASE waits for the
  // acknowledge to return low.
  function automatic snd_state_t snd_step(snd_state_t cur, logic take, logic ack_seen);
    snd_state_t nxt;
    nxt = cur;
    case (cur)
      SND_IDLE:    if (take)      nxt = SND_LOAD;
      SND_LOAD:    if (!ack_seen) nxt = SND_ASSERT;
      SND_ASSERT:  if (ack_seen)  nxt = SND_RELEASE;
      SND_RELEASE: if (!ack_seen) nxt = SND_IDLE;
      default:                    nxt = SND_IDLE;
    endcase
    return nxt;
  endfunction

  // Receiver step: wait for request high, then hold until request is low.
  function automatic rcv_state_t rcv_step(rcv_state_t cur, logic req_seen);
    rcv_state_t nxt;
    nxt = cur;
    case (cur)
      RCV_WAIT: if (req_seen)  nxt = RCV_HOLD;
      RCV_HOLD: if (!req_seen) nxt = RCV_WAIT;
      default:                 nxt = RCV_WAIT;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;

  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/hs4_sender.sv
module hs4_sender
  import hs4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             ack_seen,
  output logic             req_line,
  output logic [WIDTH-1:0] bus_word
);
  snd_state_t       state, state_nxt;
  logic             take;
  logic             req_q;
  logic [WIDTH-1:0] word_q;

  assign in_ready  = (state == SND_IDLE);
  assign take      = in_valid && in_ready;
  assign state_nxt = snd_step(state, take, ack_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SND_IDLE;
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      state <= state_nxt;
      req_q <= (state_nxt == SND_ASSERT);
      if (take) word_q <= in_data;
    end
  end

  assign req_line = req_q;
  assign bus_word = word_q;

  // R2: a taken word closes the input on the following cycle
  assert_take_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  // R3: bus unchanged while request stays high
  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && $past(req_q)) |-> $stable(word_q));

  // R4: request rises only with acknowledge seen low
  assert_req_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_seen));

  // R4: request falls only after acknowledge seen high
  assert_req_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_seen));

  // R8: input stays closed while acknowledge is seen high
  assert_ready_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |-> !in_ready);
endmodule

// File: rtl/hs4_receiver.sv
module hs4_receiver
  import hs4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_seen,
  input  logic [WIDTH-1:0] bus_word,
  output logic             ack_line,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  rcv_state_t       state, state_nxt;
  logic             capture;
  logic             ack_q;
  logic             pulse_q;
  logic [WIDTH-1:0] data_q;

  assign state_nxt = rcv_step(state, req_seen);
  assign capture   = (state == RCV_WAIT) && (state_nxt == RCV_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RCV_WAIT;
      ack_q   <= 1'b0;
      pulse_q <= 1'b0;
      data_q  <= '0;
    end else begin
      state   <= state_nxt;
      ack_q   <= (state_nxt == RCV_HOLD);
      pulse_q <= capture;
      if (capture) data_q <= bus_word;
    end
  end

  assign ack_line  = ack_q;
  assign out_valid = pulse_q;
  assign out_data  = data_q;

  // R5: acknowledge rises only after request seen high
  assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_seen));

  // R5: acknowledge falls only after request seen low
  assert_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !$past(req_seen));

  // R6: valid lasts a single cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R6: valid accompanies the rising acknowledge
  assert_pulse_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> pulse_q);
endmodule

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tx_clk,
  input  logic             tx_rst_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  output logic             rx_valid,
  output logic [WIDTH-1:0] rx_data
);
  logic             req_line;
  logic             ack_line;
  logic             req_in_rx;
  logic             ack_in_tx;
  logic [WIDTH-1:0] bus_word;

  hs4_sender #(.WIDTH(WIDTH)) u_snd (
    .clk      (tx_clk),
    .rst_n    (tx_rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .ack_seen (ack_in_tx),
    .req_line (req_line),
    .bus_word (bus_word)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (rx_clk),
    .rst_n (rx_rst_n),
    .d     (req_line),
    .q     (req_in_rx)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (tx_clk),
    .rst_n (tx_rst_n),
    .d     (ack_line),
    .q     (ack_in_tx)
  );

  hs4_receiver #(.WIDTH(WIDTH)) u_rcv (
    .clk       (rx_clk),
    .rst_n     (rx_rst_n),
    .req_seen  (req_in_rx),
    .bus_word  (bus_word),
    .ack_line  (ack_line),
    .out_valid (rx_valid),
    .out_data  (rx_data)
  );
endmodule

// File: tb/tb_hs4_link.sv
`timescale 1ns/1ps
module tb_hs4_link;
  localparam int W = 12;

  logic         tx_clk = 1'b0, rx_clk = 1'b0;
  logic         tx_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic         tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_ready, rx_valid;
  logic [W-1:0] rx_data;

  int checks = 0, errors = 0, n_sent = 0, n_got = 0;
  logic [W-1:0] exp_q[$];
  logic prev_v = 1'b0;

  always #4   tx_clk = ~tx_clk;
  always #6.5 rx_clk = ~rx_clk;

  hs4_link #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one word, then junk held on the inputs while tx_ready is low
  task automatic push(input logic [W-1:0] w, input int junk);
    do @(negedge tx_clk); while (!tx_ready);
    tx_valid = 1'b1;
    tx_data  = w;
    exp_q.push_back(w);
    n_sent++;
    @(negedge tx_clk);
    check(tx_ready == 1'b0, "R2", tx_ready, 0);
    for (int i = 0; i < junk; i++) begin
      check(tx_ready == 1'b0, "R8", tx_ready, 0);
      tx_data = ~w ^ W'(i);
      @(negedge tx_clk);
    end
    tx_valid = 1'b0;
  endtask

  // Monitor: pop and compare on each delivery pulse
  always @(negedge rx_clk) begin
    if (rx_rst_n) begin
      if (rx_valid) begin
        check(!prev_v, "R6", prev_v, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", rx_data, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, "R7", rx_data, e);
        end
        n_got++;
      end
      prev_v <= rx_valid;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tx_clk);
    errors++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", n_got, n_sent);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge tx_clk);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);
    @(negedge rx_clk); rx_rst_n = 1'b1;
    @(negedge tx_clk); tx_rst_n = 1'b1;
    repeat (4) @(negedge rx_clk);
    check(rx_valid == 1'b0, "R1", rx_valid, 0);
    check(tx_ready == 1'b1, "R1", tx_ready, 1);

    // R3 and R7: distinct bit patterns
    push(12'h000, 0);
    push(12'hFFF, 1);
    push(12'hAAA, 3);
    push(12'h555, 2);
    // R8: junk held during the round trip; incrementing run
    for (int k = 0; k < 24; k++) push(W'(k * 37 + 5), k % 4);

    while (n_got < n_sent) @(negedge tx_clk);
    repeat (20) @(negedge rx_clk);
    check(n_got == n_sent, "R7", n_got, n_sent);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    check(rx_valid == 1'b0, "R6", rx_valid, 0);
    finish_run();
  end
endmodule